// File: doc/BRIEF.md
# UART Request-to-Send Flow-Control Generator

This block drives the active-low Request-to-Send line for a UART receiver. The line is low while the receiver can take a new character. It goes high as soon as a character begins. Once the character has been received, the line goes low again, but only after a programmable number of bit-times. That waiting period is counted from the middle of the final stop bit, and a new start bit that arrives before it runs out cancels it.

The serial sampler is not part of this block. It supplies two one-cycle strobes: one when a valid start bit is seen and one at the middle of the last stop bit. It also supplies a tick once per bit-time. The configuration inputs are an enable for the handshake, the receive enable, a receiver-initialise pulse and a 4-bit delay code. The output is registered: each event on the inputs shows up on `rts_n_o` one clock later.

Top module: `rts_flow_ctrl`

## Requirements
- R1: After a synchronous reset, `rts_n_o` is 1 and no countdown is pending.
- R2: While `rts_en_i` is 0, `rts_n_o` is 1 in the next cycle and any countdown is dropped. This condition has the highest priority of all.
- R3: With handshaking enabled, no frame in progress and no countdown pending, `rx_en_i` = 1 drives `rts_n_o` to 0 in the next cycle.
- R4: A `start_det_i` strobe drives `rts_n_o` to 1 in the next cycle and marks a frame as in progress.
- R5: If `rx_en_i` is 0 while no frame is in progress, `rts_n_o` is 1 in the next cycle. This also holds during a countdown, which is then abandoned.
- R6: A `stop_mid_i` strobe with `rx_en_i` = 0 ends the frame with `rts_n_o` = 1, and the line stays 1 until `rx_en_i` is set again.
- R7: An `rx_init_i` pulse drives `rts_n_o` to 1 in the next cycle and abandons both the frame and any countdown. It has priority over the two strobes.
- R8: A `stop_mid_i` strobe with `rx_en_i` = 1 and unsigned 4-bit code `dly_code_i` = c starts a wait of 8·c bit ticks. Ticks in the strobe cycle are not counted. `rts_n_o` goes to 0 in the cycle after the 8·c-th later tick. For c = 0 it goes to 0 in the cycle after the strobe, and for c = 15 the wait is 120 ticks.
- R9: A start strobe during a countdown cancels it and leaves `rts_n_o` at 1. The next stop strobe starts a new countdown of the full length.
- R10: Between a start strobe and the following stop strobe, `rts_n_o` stays at 1 whatever `rx_en_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rts_en_i | input | 1 | Request-to-Send handshaking enable |
| rx_en_i | input | 1 | Receive enable |
| rx_init_i | input | 1 | Receiver-initialise pulse |
| dly_code_i | input | 4 | Re-assertion delay code, 8 bit-times per step |
| start_det_i | input | 1 | Valid start bit detected (one-cycle strobe) |
| stop_mid_i | input | 1 | Middle of last stop bit reached (one-cycle strobe) |
| bit_tick_i | input | 1 | One pulse per bit-time |
| rts_n_o | output | 1 | Request-to-Send, active low, registered |

## Verification
The assertions rely on the receiver strobes following frame order. A start strobe comes only when no frame is open, a stop strobe comes only inside an open frame, and the two never occur in the same cycle. The random stimulus keeps these rules by tracking frame state in the bench model and drawing each strobe only when it is legal. The receive-enable, enable, initialise and tick inputs are drawn freely. Directed sequences add the shortest and longest delay codes, a start strobe in the middle of a countdown, and receive enable dropped during a frame and during a countdown.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
package rts_pkg;
  // Number of bit-times selected by a delay code.
  function automatic int unsigned dly_len(input int unsigned code, input int unsigned step);
    return code * step;
  endfunction

  // Reason for the next value of the output, used for readability of the control logic.
  typedef enum logic [2:0] {
    CAUSE_OFF, CAUSE_INIT, CAUSE_START, CAUSE_STOP, CAUSE_WAIT, CAUSE_FRAME, CAUSE_IDLE
  } rts_cause_e;
endpackage

// File: rtl/rts_frame_trk.sv
`timescale 1ns/1ps
module rts_frame_trk (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic start_i,
  input  logic stop_i,
  output logic in_frame_o
);
  always_ff @(posedge clk) begin
    if (rst || init_i)  in_frame_o <= 1'b0;
    else if (start_i)   in_frame_o <= 1'b1;
    else if (stop_i)    in_frame_o <= 1'b0;
  end

  // R4: a start strobe opens a frame
  p_start_opens_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !init_i) |=> in_frame_o);
  // R7: initialise closes any frame
  p_init_closes_r7: assert property (@(posedge clk) disable iff (rst)
    init_i |=> !in_frame_o);
endmodule

// File: rtl/rts_dly_cnt.sv
`timescale 1ns/1ps
module rts_dly_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             busy_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)              cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && busy_o)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  // R8: without a tick the remaining wait does not move
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i && !load_i) |=> $stable(cnt_q));
  // R8: an expiring count reaches idle in the next cycle
  p_expire_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !load_i) |=> !busy_o);
endmodule

// File: rtl/rts_flow_ctrl.sv
`timescale 1ns/1ps
module rts_flow_ctrl #(
  parameter int CODE_W = 4,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rts_en_i,
  input  logic              rx_en_i,
  input  logic              rx_init_i,
  input  logic [CODE_W-1:0] dly_code_i,
  input  logic              start_det_i,
  input  logic              stop_mid_i,
  input  logic              bit_tick_i,
  output logic              rts_n_o
);
  import rts_pkg::*;

  localparam int MAX_DLY = ((1 << CODE_W) - 1) * STEP;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  logic             in_frame;
  logic             busy, expire;
  logic             cnt_load, cnt_clr;
  logic [CNT_W-1:0] dly_val;
  logic             rts_n_d;
  rts_cause_e       cause;

  rts_frame_trk u_frame (
    .clk(clk), .rst(rst), .init_i(rx_init_i),
    .start_i(start_det_i), .stop_i(stop_mid_i), .in_frame_o(in_frame)
  );

  assign dly_val = CNT_W'(dly_len(int'(dly_code_i), STEP));

  rts_dly_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr), .load_i(cnt_load),
    .load_val_i(dly_val), .tick_i(bit_tick_i),
    .busy_o(busy), .expire_o(expire)
  );

  // Priority order: enable, initialise, start, stop, countdown, frame, idle.
  always_comb begin
    if (!rts_en_i)        cause = CAUSE_OFF;
    else if (rx_init_i)   cause = CAUSE_INIT;
    else if (start_det_i) cause = CAUSE_START;
    else if (stop_mid_i)  cause = CAUSE_STOP;
    else if (busy)        cause = CAUSE_WAIT;
    else if (in_frame)    cause = CAUSE_FRAME;
    else                  cause = CAUSE_IDLE;
  end

  always_comb begin
    cnt_load = 1'b0;
    cnt_clr  = 1'b0;
    rts_n_d  = 1'b1;
    unique case (cause)
      CAUSE_OFF, CAUSE_INIT, CAUSE_START: cnt_clr = 1'b1;
      CAUSE_STOP: begin
        cnt_load = rx_en_i;
        rts_n_d  = !(rx_en_i && dly_val == '0);
      end
      CAUSE_WAIT: begin
        cnt_clr = !rx_en_i;
        rts_n_d = !(rx_en_i && expire);
      end
      CAUSE_FRAME: rts_n_d = rts_n_o;
      CAUSE_IDLE:  rts_n_d = !rx_en_i;
      default:     rts_n_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rts_n_o <= 1'b1;
    else     rts_n_o <= rts_n_d;
  end

  // R2: disabled handshake forces the line high
  p_off_high_r2: assert property (@(posedge clk) disable iff (rst)
    !rts_en_i |=> rts_n_o);
  // R7: initialise forces the line high
  p_init_high_r7: assert property (@(posedge clk) disable iff (rst)
    rx_init_i |=> rts_n_o);
  // R4: start strobe raises the line
  p_start_high_r4: assert property (@(posedge clk) disable iff (rst)
    start_det_i |=> rts_n_o);
  // R3: the line only falls while receive and handshake were enabled
  p_fall_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rts_n_o) |-> ($past(rx_en_i) && $past(rts_en_i)));
  // R10: an open frame never lets the line fall
  p_frame_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (in_frame && !stop_mid_i) |=> rts_n_o);
  // R6: frame ending with receive disabled keeps the line high
  p_stop_off_r6: assert property (@(posedge clk) disable iff (rst)
    (stop_mid_i && !rx_en_i) |=> rts_n_o);
endmodule

// File: tb/sim_rts_flow_ctrl.sv
`timescale 1ns/1ps
module sim_rts_flow_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rts_en = 1'b0, rx_en = 1'b0, rx_init = 1'b0;
  logic [3:0] code = 4'd0;
  logic       start_det = 1'b0, stop_mid = 1'b0, tick = 1'b0;
  logic       rts_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  bit    m_rts   = 1'b1;
  int    m_cnt   = 0;
  bit    m_frame = 1'b0;
  string m_tag   = "R1";

  always #2.5 clk = ~clk;

  rts_flow_ctrl u0 (
    .clk(clk), .rst(rst), .rts_en_i(rts_en), .rx_en_i(rx_en), .rx_init_i(rx_init),
    .dly_code_i(code), .start_det_i(start_det), .stop_mid_i(stop_mid),
    .bit_tick_i(tick), .rts_n_o(rts_n)
  );

  // Next expected state, computed from the requirements.
  task automatic model_step();
    bit was_frame = m_frame;
    if (rst) begin
      m_rts = 1; m_cnt = 0; m_frame = 0; m_tag = "R1";
      return;
    end
    if (rx_init) m_frame = 0;
    else if (start_det) m_frame = 1;
    else if (stop_mid) m_frame = 0;
    if (!rts_en) begin m_rts = 1; m_cnt = 0; m_tag = "R2"; end
    else if (rx_init) begin m_rts = 1; m_cnt = 0; m_tag = "R7"; end
    else if (start_det) begin
      m_tag = (m_cnt != 0) ? "R9" : "R4";
      m_rts = 1; m_cnt = 0;
    end
    else if (stop_mid) begin
      if (rx_en) begin
        m_cnt = 8 * int'(code); m_rts = (m_cnt != 0); m_tag = "R8";
      end else begin m_rts = 1; m_tag = "R6"; end
    end
    else if (m_cnt != 0) begin
      if (!rx_en) begin m_cnt = 0; m_rts = 1; m_tag = "R5"; end
      else begin
        m_tag = "R8";
        if (tick) begin
          if (m_cnt == 1) m_rts = 0;
          m_cnt = m_cnt - 1;
        end
      end
    end
    else if (was_frame) m_tag = "R10";
    else begin m_rts = !rx_en; m_tag = rx_en ? "R3" : "R5"; end
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    total++;
    if (rts_n !== m_rts) begin
      bad++;
      $display("FAIL %s: rts_n=%0b expected=%0b at %0t", m_tag, rts_n, m_rts, $time);
    end
  endtask

  task automatic drive(bit en, bit rx, bit ini, bit [3:0] c, bit st, bit sp, bit tk);
    rts_en = en; rx_en = rx; rx_init = ini; code = c;
    start_det = st; stop_mid = sp; tick = tk;
    step();
  endtask

  task automatic idle(int n, bit rx, bit tk);
    for (int i = 0; i < n; i++) drive(1, rx, 0, code, 0, 0, tk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    @(negedge clk);
    rst = 1; step(); step();          // R1 reset state
    rst = 0;
    drive(0, 1, 0, 0, 0, 0, 0);       // R2 disabled
    drive(1, 1, 0, 0, 0, 0, 0);       // R3 enable -> low
    idle(2, 1, 0);
    // R8 code 0: immediate re-assertion
    drive(1, 1, 0, 0, 1, 0, 0);       // R4
    idle(3, 1, 1);
    drive(1, 1, 0, 0, 0, 1, 1);
    idle(2, 1, 0);
    // R8 code 15: 120 ticks, every cycle
    drive(1, 1, 0, 15, 1, 0, 0);
    drive(1, 1, 0, 15, 0, 1, 1);
    idle(122, 1, 1);
    // R9 cancel mid countdown then a full new countdown
    drive(1, 1, 0, 2, 1, 0, 0);
    drive(1, 1, 0, 2, 0, 1, 0);
    idle(10, 1, 1);
    drive(1, 1, 0, 2, 1, 0, 0);
    idle(3, 1, 1);
    drive(1, 1, 0, 2, 0, 1, 0);
    idle(18, 1, 1);
    // R10 rx_en toggles inside frame, R6 frame ends disabled
    drive(1, 1, 0, 1, 1, 0, 0);
    idle(2, 0, 1); idle(2, 1, 1);
    drive(1, 0, 0, 1, 0, 1, 0);
    idle(3, 0, 1);
    idle(2, 1, 0);
    // R5 drop rx_en during countdown, R7 init during frame
    drive(1, 1, 0, 3, 1, 0, 0);
    drive(1, 1, 0, 3, 0, 1, 0);
    idle(4, 1, 1);
    idle(2, 0, 1);
    idle(2, 1, 1);
    drive(1, 1, 0, 3, 1, 0, 0);
    drive(1, 1, 1, 3, 0, 0, 0);
    idle(3, 1, 1);
    // constrained random
    for (int i = 0; i < 20000; i++) begin
      bit en  = ($urandom % 40) != 0;
      bit rx  = ($urandom % 8) != 0;
      bit ini = ($urandom % 150) == 0;
      bit [3:0] c = 4'($urandom % 4);
      bit st = 0, sp = 0;
      bit tk = ($urandom % 3) == 0;
      if (!m_frame) st = ($urandom % 25) == 0;
      else          sp = ($urandom % 12) == 0;
      if (($urandom % 20) == 0) c = 4'($urandom);
      drive(en, rx, ini, c, st, sp, tk);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule